// File: doc/BRIEF.md
# Four-Lane Parallel Sine Synthesizer

This block is a direct digital synthesizer for a converter that samples four times faster than the logic feeding it. On every fabric clock it emits one wide word holding four consecutive sine samples in time order, so a downstream serializer running at the converter rate can shift them out back to back. The sample stream has no gaps and no repeats.

A single phase accumulator is shared by the four lanes. Lane k reads the accumulator plus k times the tuning increment. The multiples of the increment are computed once, when a new tuning word is written, and are not recomputed every cycle. The top bits of each lane phase address a sine table. All four lanes read the table in the same cycle, so every lane has its own read port.

A tuning write takes effect on the next word boundary and keeps the phase continuous. A synchronous reset loads the accumulator with the phase offset applied at the input and clears the increment.

Top module: `quad_sine_dds`

## Requirements
- R1: Within each output word, consecutive lanes are separated in phase by exactly the current tuning increment, so lane k carries sample n+k.
- R2: The word after a word whose lane 0 has phase p (with no tuning write in between) has lane 0 phase p + 4·increment. Every sample of the stream is therefore one increment after the sample before it.
- R3: Each lane value is the signed 16-bit two's-complement number round(32767·sin(2π·i/1024)), where i is bits [31:22] of that lane's 32-bit phase.
- R4: Lane k occupies bits [16k+15:16k] of `samples`, so lane 0 sits in the least significant 16 bits.
- R5: A tuning write, sampled with `tune_wr` high at a clock edge, leaves the word computed at that edge unchanged. In the next word, lane 0 has phase (last lane of the previous word) + new increment, and all of its lanes use the new increment. Writes on consecutive cycles each apply in turn.
- R6: A clock edge with `rst` high loads the accumulator with `phase_ofs` and sets the increment to 0. It takes precedence over a tuning write in the same cycle. `phase_ofs` has no effect while `rst` is low.
- R7: `samples_vld` is low after any reset edge and after the first edge following reset release. It goes high after the second edge, when that edge presents the word computed at the first edge, and stays high until the next reset.
- R8: Phase arithmetic wraps modulo 2^32. This includes increments close to 2^32 and offsets just below 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, one quarter of the converter rate |
| rst | input | 1 | Synchronous reset, active high |
| tune_wr | input | 1 | Loads `tune_word` as the new phase increment |
| tune_word | input | 32 | Phase increment per converter sample |
| phase_ofs | input | 32 | Start phase, loaded into the accumulator while reset is high |
| samples | output | 64 | Four signed 16-bit samples, lane 0 in the low bits |
| samples_vld | output | 1 | High when `samples` holds a valid word |

## Verification
A tuning write can fall in the same cycle as a reset, and it can also land on the edge where a word is being computed. The bench drives a write together with reset, where reset must win and the increment must read 0. It also issues writes on consecutive cycles, so that every word boundary carries a change of increment. A behavioural model steps through the sample stream one increment at a time and applies each write after the last lane of the current word. Every valid word is compared lane by lane against table values computed from that model.

// File: rtl/quad_sine_dds.sv
module quad_sine_dds #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10,
  parameter int SAMP_W  = 16,
  parameter int LANES   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tune_wr,
  input  logic [PHASE_W-1:0]        tune_word,
  input  logic [PHASE_W-1:0]        phase_ofs,
  output logic [LANES*SAMP_W-1:0]   samples,
  output logic                      samples_vld
);

  localparam int  DEPTH  = 1 << ADDR_W;
  localparam real AMP    = (2.0 ** (SAMP_W - 1)) - 1.0;
  localparam real TWO_PI = 6.283185307179586;

  logic [PHASE_W-1:0]       acc;
  logic [PHASE_W-1:0]       step [LANES+1];
  logic [PHASE_W-1:0]       ph   [LANES];
  logic signed [SAMP_W-1:0] lane_q [LANES];
  logic signed [SAMP_W-1:0] rom  [DEPTH];
  logic                     fill;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      real r;
      r = AMP * $sin(TWO_PI * i / DEPTH);
      rom[i] = (r >= 0.0) ? SAMP_W'($rtoi(r + 0.5)) : SAMP_W'(-$rtoi(0.5 - r));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= phase_ofs;
      for (int k = 0; k <= LANES; k++) step[k] <= '0;
    end else if (tune_wr) begin
      acc <= acc + step[LANES-1] + tune_word;
      for (int k = 0; k <= LANES; k++) step[k] <= PHASE_W'(k) * tune_word;
    end else begin
      acc <= acc + step[LANES];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill        <= 1'b0;
      samples_vld <= 1'b0;
    end else begin
      fill        <= 1'b1;
      samples_vld <= fill;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk) begin
      ph[k]     <= acc + step[k];
      lane_q[k] <= rom[ph[k][PHASE_W-1 -: ADDR_W]];
    end
    assign samples[k*SAMP_W +: SAMP_W] = lane_q[k];

    if (k > 0) begin : g_spacing
      a_r1_lane_spacing: assert property (@(posedge clk) disable iff (rst)
        fill |-> (ph[k] - ph[k-1]) == $past(step[1]));
    end
  end

  a_r2_word_continuity: assert property (@(posedge clk) disable iff (rst)
    (fill && $past(fill)) |-> ph[0] == $past(ph[LANES-1]) + $past(step[1]));

  a_r7_vld_low_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !samples_vld);

  a_r7_vld_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(samples_vld) |-> samples_vld);

  a_r7_vld_needs_fill: assert property (@(posedge clk) disable iff (rst)
    $rose(samples_vld) |-> $past(fill));

endmodule

// File: tb/quad_sine_dds_tb.sv
module quad_sine_dds_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        tune_wr;
  logic [31:0] tune_word;
  logic [31:0] phase_ofs;
  logic [63:0] samples;
  logic        samples_vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag = "R7";

  logic [31:0] m_next, m_inc;
  logic [63:0] q[$];
  logic [63:0] exp_w;
  bit          exp_vld = 1'b0;

  always #2 clk = ~clk;

  quad_sine_dds u_dut (
    .clk(clk), .rst(rst), .tune_wr(tune_wr), .tune_word(tune_word),
    .phase_ofs(phase_ofs), .samples(samples), .samples_vld(samples_vld)
  );

  function automatic logic [15:0] sref(input logic [31:0] ph);
    int  idx;
    real r;
    idx = int'(ph[31:22]);
    r = 32767.0 * $sin(6.283185307179586 * idx / 1024);
    return (r >= 0.0) ? 16'($rtoi(r + 0.5)) : 16'(-$rtoi(0.5 - r));
  endfunction

  // Behavioural model: walk the sample stream one increment at a time.
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_next = phase_ofs;
      m_inc  = 32'd0;
    end else begin
      logic [63:0] w;
      logic [31:0] p;
      p = m_next;
      for (int k = 0; k < 4; k++) begin
        w[16*k +: 16] = sref(p);
        if (k < 3) p = p + m_inc;
      end
      if (tune_wr) m_inc = tune_word;
      m_next = p + m_inc;
      q.push_back(w);
    end
    exp_vld = (q.size() == 2);
    if (exp_vld) exp_w = q.pop_front();
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (samples_vld !== exp_vld) begin
        fails++;
        $display("FAIL %s R7 valid got %0b exp %0b", tag, samples_vld, exp_vld);
      end
      if (exp_vld) begin
        for (int k = 0; k < 4; k++) begin
          checks++;
          if (samples[16*k +: 16] !== exp_w[16*k +: 16]) begin
            fails++;
            $display("FAIL %s R1 R3 R4 lane%0d got %0d exp %0d", tag, k,
                     $signed(samples[16*k +: 16]), $signed(exp_w[16*k +: 16]));
          end
        end
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tune(input logic [31:0] v);
    tune_wr = 1'b1; tune_word = v;
    @(negedge clk);
    tune_wr = 1'b0;
  endtask

  initial begin
    rst = 1'b1; tune_wr = 1'b0; tune_word = '0; phase_ofs = 32'h4000_0000;
    tag = "R7"; cycles(4);
    rst = 1'b0; cycles(6);              // R6: increment 0, constant offset phase
    tag = "R5"; tune(32'h0123_4567); cycles(20);
    tag = "R2"; tune(32'h0000_8000); cycles(30);
    tag = "R6"; phase_ofs = 32'h1234_5678; cycles(10);   // offset ignored while running
    tag = "R8"; tune(32'hFFFF_F000); cycles(20);
    tune(32'hFFC0_0001); cycles(30);
    tag = "R5"; tune(32'h0100_0000); tune(32'h0300_0000); tune(32'h0050_0000); cycles(10);
    tag = "R1"; tune(32'h4000_0000); cycles(8);
    // R6: reset and tuning write collide; reset must win
    tag = "R6"; phase_ofs = 32'hFFFF_FFFF;
    rst = 1'b1; tune_wr = 1'b1; tune_word = 32'h0777_0000; cycles(1);
    tune_wr = 1'b0; cycles(2); rst = 1'b0; cycles(6);
    tag = "R8"; tune(32'h8000_0001); cycles(40);
    tag = "R2"; tune(32'h0000_0001); cycles(20);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule